// File: doc/BRIEF.md
# Video Write Snooper with Panel Scan-Out

This block builds a display picture without taking any memory cycles from the CPU. It watches the CPU's write strobe, address and data. Any byte stored inside a configurable video window is copied into a local frame buffer. In parallel, a scan engine reads that buffer and produces the picture for a 128x64 monochrome panel. The panel is organised as eight horizontal bands of eight rows. The scan engine emits one byte per band column over a valid/ready stream, and the serial link to the panel consumes that stream.

The low-resolution source image is stretched to fit the panel:

- Each source column is drawn twice across.
- Rows are repeated, used directly, or thinned to every other row, depending on how tall the source image is.

A free-running divider also raises a vertical interrupt request at the refresh rate. This keeps CPU software that counts frames working. The request is held until the CPU acknowledges it.

Top module: `video_snoop`

## Requirements
- R1: On a clock edge with `cpuWrEn` high, let off = (`cpuAddr` − `pageBase`) mod 2^ADDR_W. If off is below the window size of 8 × source rows bytes, buffer byte off takes `cpuData`. Any other write has no effect on the picture.
- R2: `rowMode` selects the source height: 0 gives 32 rows, 1 gives 64 rows, 2 gives 128 rows, and 3 behaves as 1.
- R3: A source row occupies 8 consecutive buffer bytes. Pixel (row r, column c) is bit 7−(c mod 8) of byte 8r + c/8, so bit 7 is the leftmost pixel.
- R4: Panel column x shows source column x/2 (integer division), so each source pixel is two panel pixels wide.
- R5: Panel row y shows source row y/2 for 32 rows, row y for 64 rows, and row 2y for 128 rows. With 128 rows, odd rows are skipped.
- R6: An output byte for band p and column c carries panel row 8p+k in bit k. Bytes run through columns 0..127 of band 0, then band 1, and so on up to band 7.
- R7: While `pixValid` is high and `pixReady` is low, `pixData` and `pixLast` hold steady. Once raised after reset, `pixValid` never drops. The stream advances one position per accepted byte.
- R8: `pixLast` is high only on the byte for band 7, column 127. The byte after it is band 0, column 0 of the next frame.
- R9: Each byte's contents are taken from the buffer as it stood just before the edge that loads it. The loading edges are the first edge after reset and the edge on which the previous byte is accepted.
- R10: `irqReq` rises on every TICK_DIV-th edge after reset, where TICK_DIV = CLK_HZ/REFRESH_HZ. It then stays high until an edge with `irqAck` high and no new tick. A tick wins over a simultaneous acknowledge.
- R11: During reset, `pixValid`, `irqReq` and every buffer byte are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuWrEn | input | 1 | CPU memory write strobe, one cycle per write |
| cpuAddr | input | ADDR_W | CPU write address |
| cpuData | input | 8 | CPU write data |
| pageBase | input | ADDR_W | First address of the video window |
| rowMode | input | 2 | Source height select |
| irqAck | input | 1 | CPU acknowledge of the vertical interrupt |
| irqReq | output | 1 | Vertical interrupt request |
| pixValid | output | 1 | Stream byte valid |
| pixReady | input | 1 | Stream byte accepted by the panel link |
| pixData | output | 8 | Eight vertically stacked panel pixels, bit 0 on top |
| pixLast | output | 1 | Marks the final byte of a frame |

## Verification
A corrupted or misplaced buffer byte stays invisible until the scan next reaches the columns it feeds. It therefore shows on `pixData` within one frame of 1024 accepted bytes. A mis-stepped scan position shows on the very next accepted byte as wrong pixel content, and within a frame as a misplaced `pixLast`. A wrong interrupt divider or acknowledge path shows on `irqReq` within TICK_DIV cycles. For these reasons the stream and the interrupt line are compared against a behavioural model on every clock, under random stalls, writes both inside and outside the window, and all four height settings.

// File: rtl/video_snoop_pkg.sv
package video_snoop_pkg;
  // Source image width and the fixed panel geometry
  localparam int SRC_COLS     = 64;
  localparam int PANEL_COLS   = 2 * SRC_COLS;
  localparam int PANEL_ROWS   = 64;
  localparam int BAND_ROWS    = 8;
  localparam int PANEL_BANDS  = PANEL_ROWS / BAND_ROWS;
  localparam int MAX_SRC_ROWS = 2 * PANEL_ROWS;
  localparam int ROW_BYTES    = SRC_COLS / 8;
  localparam int BUF_BYTES    = MAX_SRC_ROWS * ROW_BYTES;

  localparam int COL_W  = $clog2(PANEL_COLS);
  localparam int BAND_W = $clog2(PANEL_BANDS);
  localparam int OFF_W  = $clog2(BUF_BYTES);

  typedef enum logic [1:0] {
    HEIGHT_HALF   = 2'd0,
    HEIGHT_FULL   = 2'd1,
    HEIGHT_DOUBLE = 2'd2,
    HEIGHT_ALT    = 2'd3
  } heightSel_e;

  // Strobes from the scan control to the datapath
  typedef struct packed {
    logic              load;
    logic [BAND_W-1:0] band;
    logic [COL_W-1:0]  col;
  } scanCmd_t;
endpackage

// File: rtl/video_snoop_dp.sv
module video_snoop_dp
  import video_snoop_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuWrEn,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [7:0]        cpuData,
  input  logic [ADDR_W-1:0] pageBase,
  input  logic [1:0]        rowMode,
  input  scanCmd_t          cmd,
  output logic [7:0]        pixData
);
  localparam int SROW_W = $clog2(MAX_SRC_ROWS);
  localparam int SCOL_W = $clog2(SRC_COLS);
  localparam int SUB_W  = $clog2(BAND_ROWS);
  localparam int PROW_W = BAND_W + SUB_W;

  heightSel_e        height;
  logic [ADDR_W-1:0] offset;
  logic [ADDR_W-1:0] windowBytes;
  logic              inWindow;
  logic [7:0]        frameBuf [BUF_BYTES];
  logic [SCOL_W-1:0] srcCol;
  logic [7:0]        colBits;

  assign height = heightSel_e'(rowMode);

  // Address comparator: unsigned distance from the window base
  assign offset = cpuAddr - pageBase;

  always_comb begin
    case (height)
      HEIGHT_HALF:   windowBytes = ADDR_W'((PANEL_ROWS / 2) * ROW_BYTES);
      HEIGHT_DOUBLE: windowBytes = ADDR_W'(MAX_SRC_ROWS * ROW_BYTES);
      default:       windowBytes = ADDR_W'(PANEL_ROWS * ROW_BYTES);
    endcase
  end

  assign inWindow = cpuWrEn && (offset < windowBytes);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < BUF_BYTES; i++) frameBuf[i] <= '0;
    end else if (inWindow) begin
      frameBuf[offset[OFF_W-1:0]] <= cpuData;
    end
  end

  // Horizontal doubling: two panel columns per source column
  assign srcCol = SCOL_W'(cmd.col >> 1);

  for (genvar k = 0; k < BAND_ROWS; k++) begin : g_row
    logic [PROW_W-1:0] panelRow;
    logic [SROW_W-1:0] srcRow;
    logic [7:0]        srcByte;

    assign panelRow = {cmd.band, SUB_W'(k)};

    always_comb begin
      case (height)
        HEIGHT_HALF:   srcRow = SROW_W'(panelRow >> 1);
        HEIGHT_DOUBLE: srcRow = SROW_W'({panelRow, 1'b0});
        default:       srcRow = SROW_W'(panelRow);
      endcase
    end

    assign srcByte    = frameBuf[{srcRow, srcCol[SCOL_W-1:3]}];
    assign colBits[k] = srcByte[~srcCol[2:0]];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pixData <= '0;
    else if (cmd.load) pixData <= colBits;
  end
endmodule

// File: rtl/video_snoop_ctrl.sv
module video_snoop_ctrl
  import video_snoop_pkg::*;
#(
  parameter int TICK_DIV = 833333
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     pixReady,
  input  logic     irqAck,
  output scanCmd_t cmd,
  output logic     pixValid,
  output logic     pixLast,
  output logic     irqReq
);
  localparam int                CNT_W     = $clog2(TICK_DIV + 1);
  localparam logic [CNT_W-1:0]  CNT_TOP   = CNT_W'(TICK_DIV - 1);
  localparam logic [COL_W-1:0]  COL_LAST  = COL_W'(PANEL_COLS - 1);
  localparam logic [BAND_W-1:0] BAND_LAST = BAND_W'(PANEL_BANDS - 1);

  logic [BAND_W-1:0] curBand, nxtBand;
  logic [COL_W-1:0]  curCol, nxtCol;
  logic              advance;
  logic [CNT_W-1:0]  tickCnt;
  logic              tick;

  // Position of the byte after the one on the stream
  always_comb begin
    nxtCol  = curCol + 1'b1;
    nxtBand = curBand;
    if (curCol == COL_LAST) begin
      nxtCol  = '0;
      nxtBand = (curBand == BAND_LAST) ? '0 : curBand + 1'b1;
    end
  end

  assign advance  = pixValid && pixReady;
  assign cmd.load = !pixValid || pixReady;
  assign cmd.band = advance ? nxtBand : curBand;
  assign cmd.col  = advance ? nxtCol : curCol;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curBand  <= '0;
      curCol   <= '0;
      pixValid <= 1'b0;
      pixLast  <= 1'b0;
    end else begin
      if (advance) begin
        curBand <= nxtBand;
        curCol  <= nxtCol;
      end
      if (cmd.load) begin
        pixValid <= 1'b1;
        pixLast  <= (cmd.band == BAND_LAST) && (cmd.col == COL_LAST);
      end
    end
  end

  // Refresh-rate divider and held interrupt request
  assign tick = (tickCnt == CNT_TOP);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickCnt <= '0;
      irqReq  <= 1'b0;
    end else begin
      tickCnt <= tick ? '0 : tickCnt + 1'b1;
      if (tick) irqReq <= 1'b1;
      else if (irqAck) irqReq <= 1'b0;
    end
  end
endmodule

// File: rtl/video_snoop.sv
module video_snoop
  import video_snoop_pkg::*;
#(
  parameter int CLK_HZ     = 50_000_000,
  parameter int REFRESH_HZ = 60,
  parameter int ADDR_W     = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuWrEn,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [7:0]        cpuData,
  input  logic [ADDR_W-1:0] pageBase,
  input  logic [1:0]        rowMode,
  input  logic              irqAck,
  output logic              irqReq,
  output logic              pixValid,
  input  logic              pixReady,
  output logic [7:0]        pixData,
  output logic              pixLast
);
  localparam int TICK_DIV = CLK_HZ / REFRESH_HZ;

  scanCmd_t scanCmd;

  video_snoop_ctrl #(.TICK_DIV(TICK_DIV)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .pixReady (pixReady),
    .irqAck   (irqAck),
    .cmd      (scanCmd),
    .pixValid (pixValid),
    .pixLast  (pixLast),
    .irqReq   (irqReq)
  );

  video_snoop_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .cpuWrEn  (cpuWrEn),
    .cpuAddr  (cpuAddr),
    .cpuData  (cpuData),
    .pageBase (pageBase),
    .rowMode  (rowMode),
    .cmd      (scanCmd),
    .pixData  (pixData)
  );
endmodule

// File: rtl/video_snoop_chk.sv
module video_snoop_chk (
  input logic       clk,
  input logic       rstN,
  input logic       pixValid,
  input logic       pixReady,
  input logic [7:0] pixData,
  input logic       pixLast,
  input logic       irqReq,
  input logic       irqAck
);
  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    pixValid && !pixReady |=> $stable(pixData) && $stable(pixLast));

  // R7
  valid_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    pixValid |=> pixValid);

  // R8
  last_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    pixValid && pixReady && pixLast |=> !pixLast);

  // R10
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqReq && !irqAck |=> irqReq);

  // R10
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irqReq) |-> $past(irqAck));
endmodule

bind video_snoop video_snoop_chk chk (
  .clk      (clk),
  .rstN     (rstN),
  .pixValid (pixValid),
  .pixReady (pixReady),
  .pixData  (pixData),
  .pixLast  (pixLast),
  .irqReq   (irqReq),
  .irqAck   (irqAck)
);

// File: tb/video_snoop_test.sv
`timescale 1ns/1ps
module video_snoop_test;
  localparam int DIV = 100;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cpuWrEn = 1'b0;
  logic [15:0] cpuAddr = '0;
  logic [7:0]  cpuData = '0;
  logic [15:0] pageBase = '0;
  logic [1:0]  rowMode = 2'd1;
  logic        irqAck = 1'b0;
  logic        pixReady = 1'b0;
  logic        irqReq, pixValid, pixLast;
  logic [7:0]  pixData;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  video_snoop #(.CLK_HZ(DIV * 60), .REFRESH_HZ(60), .ADDR_W(16)) uut (
    .clk(clk), .rstN(rstN), .cpuWrEn(cpuWrEn), .cpuAddr(cpuAddr),
    .cpuData(cpuData), .pageBase(pageBase), .rowMode(rowMode),
    .irqAck(irqAck), .irqReq(irqReq), .pixValid(pixValid),
    .pixReady(pixReady), .pixData(pixData), .pixLast(pixLast)
  );

  // Behavioural reference model
  byte unsigned mbuf [1024];
  int  mBand = 0, mCol = 0, mCnt = 0;
  bit  mValid = 0, mLast = 0, mIrq = 0;
  byte unsigned mData = 0;

  function automatic int srcRowsOf(input logic [1:0] m);
    if (m == 2'd0) return 32;
    if (m == 2'd2) return 128;
    return 64;
  endfunction

  function automatic byte unsigned modelByte(input int band, input int col, input logic [1:0] m);
    byte unsigned b = 0;
    int rows = srcRowsOf(m);
    for (int k = 0; k < 8; k++) begin
      int y = band * 8 + k;
      int sy = (rows == 32) ? y / 2 : (rows == 128) ? y * 2 : y;
      int sx = col / 2;
      if ((mbuf[sy * 8 + sx / 8] >> (7 - sx % 8)) & 1) b |= byte'(1 << k);
    end
    return b;
  endfunction

  initial for (int i = 0; i < 1024; i++) mbuf[i] = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 1024; i++) mbuf[i] = 0;
      mBand = 0; mCol = 0; mCnt = 0; mValid = 0; mLast = 0; mIrq = 0; mData = 0;
    end else begin
      logic [15:0] off;
      if (!mValid || pixReady) begin
        if (mValid) begin
          mCol = mCol + 1;
          if (mCol == 128) begin mCol = 0; mBand = (mBand + 1) % 8; end
        end
        mData  = modelByte(mBand, mCol, rowMode);
        mLast  = (mBand == 7) && (mCol == 127);
        mValid = 1;
      end
      off = cpuAddr - pageBase;
      if (cpuWrEn && int'(off) < srcRowsOf(rowMode) * 8) mbuf[off] = cpuData;
      if (mCnt == DIV - 1) begin mCnt = 0; mIrq = 1; end
      else begin mCnt = mCnt + 1; if (irqAck) mIrq = 0; end
    end
  end

  // Compare on every falling edge
  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (pixValid !== mValid) begin
        failures++;
        $display("FAIL %s pixValid actual %b expected %b", rstN ? "R7" : "R11", pixValid, mValid);
      end
      checks++;
      if (irqReq !== mIrq) begin
        failures++;
        $display("FAIL %s irqReq actual %b expected %b", rstN ? "R10" : "R11", irqReq, mIrq);
      end
      if (mValid) begin
        checks++;
        if (pixData !== mData) begin
          failures++;
          $display("FAIL R6 pixData (R1 R2 R3 R4 R5 R9) band %0d col %0d mode %0d actual %h expected %h",
                   mBand, mCol, rowMode, pixData, mData);
        end
        checks++;
        if (pixLast !== mLast) begin
          failures++;
          $display("FAIL R8 pixLast band %0d col %0d actual %b expected %b", mBand, mCol, pixLast, mLast);
        end
      end
    end
  end

  task automatic runPhase(input int cycles, input int readyPct, input int wrPct);
    for (int n = 0; n < cycles; n++) begin
      @(negedge clk);
      pixReady = ($urandom % 100) < readyPct;
      irqAck   = ($urandom % 100) < 4;
      cpuWrEn  = ($urandom % 100) < wrPct;
      cpuAddr  = pageBase + 16'($urandom % 1200) - 16'd50;
      cpuData  = 8'($urandom);
    end
  endtask

  initial begin
    // R11: reset state compared on every cycle while held
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 R2 R5: full-height source, window away from zero
    pageBase = 16'h0200; rowMode = 2'd1;
    runPhase(3000, 70, 60);
    // R5: half-height source with row repetition, window wrapping the address space
    pageBase = 16'hFF80; rowMode = 2'd0;
    runPhase(3000, 70, 60);
    // R5: double-height source, odd rows skipped
    pageBase = 16'h8000; rowMode = 2'd2;
    runPhase(3000, 70, 60);
    // R2: setting 3 behaves as 64 rows
    pageBase = 16'h0000; rowMode = 2'd3;
    runPhase(3000, 70, 60);
    // R7 R9: long stall while writes land, then full-rate frames
    rowMode = 2'd1;
    runPhase(300, 0, 80);
    runPhase(2500, 100, 30);
    // R1: writes stop; frame must settle and repeat unchanged
    runPhase(2200, 90, 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL R7 watchdog expired actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
      $finish;
    end
  end
endmodule